// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block is a register-mapped timer peripheral with a parameterised number of independent channels (two by default). All channels run from one functional clock. Each channel has a 16-bit down-counter fed by its own power-of-two prescaler, and its own small register window. Software writes a reload value, then sets the enable and interrupt-enable bits. The channel counts prescaled ticks down from the reload value and flags an expiry. On expiry it either reloads and keeps running, or it stops.

Each channel drives its own level interrupt. That interrupt is high while the channel's pending flag and its interrupt enable are both set. Software clears the pending flag by writing a one to it. The register port is a plain synchronous interface: a write strobe, a read strobe, a byte address and 16-bit data. Read data is registered.

Top module: `chan_timer`

## Requirements
- R1: After a synchronous reset, every register of every channel reads 0, every interrupt output is 0 and rdata is 0.
- R2: Channel c occupies byte addresses 0x80 + c*0x80 upward, with control at +0x0, status at +0x4, reload at +0x8 and count at +0xC. A read strobe sampled at a clock edge puts the addressed value on rdata at that edge. Any other address, including offsets past the last channel, reads 0.
- R3: In the control register, bit 8 is interrupt enable, bit 5 is counter enable, bit 4 selects one-shot mode and bits 3:0 are the prescaler code. Every other bit reads 0.
- R4: With prescaler code n, a running channel takes one tick every 2^n clocks, and codes above 8 behave as 8. Any write to a channel's control register restarts its divider, and no tick is taken in the cycle of that write.
- R5: A control write that sets enable while the channel is stopped loads the count from the reload register. Writes to the count offset have no effect, and a stopped channel's count does not change.
- R6: On each tick the count decreases by one. A tick that finds the count at 1 or 0 is an expiry, so a reload value of N gives an expiry N ticks after enable.
- R7: With the one-shot bit clear, an expiry reloads the count from the reload register and the channel stays enabled.
- R8: With the one-shot bit set, an expiry clears the enable bit and the count holds at 0.
- R9: Status bit 0 is set on expiry. Writing 1 to it clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R10: Each interrupt output equals that channel's pending flag ANDed with its interrupt enable bit, and it changes in the same cycle as those bits.
- R11: Channels are independent: activity on one channel never changes another channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock shared by all channels |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | NUM_CH | Level interrupt, one bit per channel |

## Verification
The bench builds the block with its defaults: two channels, 16-bit registers, a 10-bit address and a largest prescaler code of 8. With these values a divide-by-256 expiry is reached within a few hundred cycles. An out-of-range code of 9 can be shown to clamp to the same period. Because the address space is wider than the two channels use, the empty window of a third channel is also within reach. A behavioural model of both channels is compared with irq and rdata on every clock, including during a phase of random register traffic. Directed interval measurements check the exact tick counts of the expiries.

// File: rtl/chan_timer_pkg.sv
package chan_timer_pkg;
  // control field positions
  localparam int CTL_IE_BIT = 8;
  localparam int CTL_EN_BIT = 5;
  localparam int CTL_OS_BIT = 4;
  localparam int CTL_PS_W   = 4;
  // status field position
  localparam int STS_PEND_BIT = 0;
  // register offsets inside a channel window
  localparam int OFF_CTRL   = 0;
  localparam int OFF_STATUS = 4;
  localparam int OFF_RELOAD = 8;
  localparam int OFF_COUNT  = 12;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int MAX_CODE = 8,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int DIV_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  mask;
  logic [CODE_W-1:0] eff;

  always_comb begin
    eff  = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    mask = ~({DIV_W{1'b1}} << eff);
    tick = run && (div_q == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !run || tick) div_q <= '0;
    else                            div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ct_channel.sv
module ct_channel
  import chan_timer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MAX_CODE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_status,
  input  logic              wr_reload,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] status_rd,
  output logic [DATA_W-1:0] reload_rd,
  output logic [DATA_W-1:0] count_rd,
  output logic              irq
);
  logic                ie_q, en_q, os_q, pend_q, irq_q;
  logic [CTL_PS_W-1:0] ps_q;
  logic [DATA_W-1:0]   reload_q, count_q;

  logic                ie_n, en_n, os_n, pend_n, expire;
  logic [CTL_PS_W-1:0] ps_n;
  logic [DATA_W-1:0]   reload_n, count_n;
  logic                tick;

  ct_prescaler #(.MAX_CODE(MAX_CODE), .CODE_W(CTL_PS_W)) u_div (
    .clk (clk),
    .rst (rst),
    .clr (wr_ctrl),
    .run (en_q),
    .code(ps_q),
    .tick(tick)
  );

  always_comb begin
    ie_n    = ie_q;
    en_n    = en_q;
    os_n    = os_q;
    ps_n    = ps_q;
    count_n = count_q;
    expire  = 1'b0;
    if (wr_ctrl) begin
      ie_n = wdata[CTL_IE_BIT];
      en_n = wdata[CTL_EN_BIT];
      os_n = wdata[CTL_OS_BIT];
      ps_n = wdata[CTL_PS_W-1:0];
      if (wdata[CTL_EN_BIT] && !en_q) count_n = reload_q;
    end else if (tick) begin
      if (count_q <= DATA_W'(1)) begin
        expire = 1'b1;
        if (os_q) begin
          en_n    = 1'b0;
          count_n = '0;
        end else begin
          count_n = reload_q;
        end
      end else begin
        count_n = count_q - 1'b1;
      end
    end
    if (expire)                             pend_n = 1'b1;
    else if (wr_status && wdata[STS_PEND_BIT]) pend_n = 1'b0;
    else                                    pend_n = pend_q;
    reload_n = wr_reload ? wdata : reload_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q     <= 1'b0;
      en_q     <= 1'b0;
      os_q     <= 1'b0;
      ps_q     <= '0;
      pend_q   <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      ie_q     <= ie_n;
      en_q     <= en_n;
      os_q     <= os_n;
      ps_q     <= ps_n;
      pend_q   <= pend_n;
      reload_q <= reload_n;
      count_q  <= count_n;
      irq_q    <= pend_n & ie_n;
    end
  end

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[CTL_IE_BIT]     = ie_q;
    ctrl_rd[CTL_EN_BIT]     = en_q;
    ctrl_rd[CTL_OS_BIT]     = os_q;
    ctrl_rd[CTL_PS_W-1:0]   = ps_q;
    status_rd               = '0;
    status_rd[STS_PEND_BIT] = pend_q;
  end

  assign reload_rd = reload_q;
  assign count_rd  = count_q;
  assign irq       = irq_q;
endmodule

// File: rtl/chan_timer.sv
module chan_timer
  import chan_timer_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int MAX_CODE  = 8,
  parameter int CH_BASE   = 128,
  parameter int CH_STRIDE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [31:0]                   addr_w;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl, ch_status, ch_reload, ch_count, rd_val;
  logic [NUM_CH-1:0]             ch_pend;
  logic [DATA_W-1:0]             rd_any;

  assign addr_w = 32'(addr);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = CH_BASE + c * CH_STRIDE;
    logic [31:0] off;
    logic        hit;

    assign off = addr_w - 32'(BASE);
    assign hit = (addr_w >= 32'(BASE)) && (off < 32'(CH_STRIDE));

    ct_channel #(.DATA_W(DATA_W), .MAX_CODE(MAX_CODE)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_ctrl  (wr_en && hit && (off == 32'(OFF_CTRL))),
      .wr_status(wr_en && hit && (off == 32'(OFF_STATUS))),
      .wr_reload(wr_en && hit && (off == 32'(OFF_RELOAD))),
      .wdata    (wdata),
      .ctrl_rd  (ch_ctrl[c]),
      .status_rd(ch_status[c]),
      .reload_rd(ch_reload[c]),
      .count_rd (ch_count[c]),
      .irq      (irq[c])
    );

    assign ch_pend[c] = ch_status[c][STS_PEND_BIT];
    assign rd_val[c]  = !hit                        ? '0 :
                        (off == 32'(OFF_CTRL))      ? ch_ctrl[c] :
                        (off == 32'(OFF_STATUS))    ? ch_status[c] :
                        (off == 32'(OFF_RELOAD))    ? ch_reload[c] :
                        (off == 32'(OFF_COUNT))     ? ch_count[c] : '0;
  end

  always_comb begin
    rd_any = '0;
    for (int c = 0; c < NUM_CH; c++) rd_any |= rd_val[c];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_any;
  end
endmodule

// File: rtl/ct_checker.sv
module ct_checker
  import chan_timer_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 10,
  parameter int CH_BASE = 128
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic                          rd_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [DATA_W-1:0]             rdata,
  input logic [NUM_CH-1:0]             irq,
  input logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl,
  input logic [NUM_CH-1:0][DATA_W-1:0] ch_count,
  input logic [NUM_CH-1:0]             ch_pend
);
  AST_LOW_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (32'(addr) < 32'(CH_BASE))) |=> (rdata == '0)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_IRQ_IS_PEND_AND_IE: assert property (@(posedge clk) disable iff (rst)
      irq[c] == (ch_pend[c] && ch_ctrl[c][CTL_IE_BIT])); // R10

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
      ($rose(ch_pend[c]) && ch_ctrl[c][CTL_OS_BIT]) |-> !ch_ctrl[c][CTL_EN_BIT]); // R8

    AST_IDLE_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!ch_ctrl[c][CTL_EN_BIT] && !wr_en) |=> $stable(ch_count[c])); // R5

    AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (rst)
      ($rose(ch_pend[c]) && ch_ctrl[c][CTL_OS_BIT]) |-> (ch_count[c] == '0)); // R8
  end
endmodule

bind chan_timer ct_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CH_BASE(CH_BASE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .irq     (irq),
  .ch_ctrl (ch_ctrl),
  .ch_count(ch_count),
  .ch_pend (ch_pend)
);

// File: tb/sim_chan_timer.sv
module sim_chan_timer;
  localparam int NCH = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NCH-1:0] irq;

  int checks = 0, errors = 0, cyc = 0;

  chan_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ie[NCH], m_en[NCH], m_os[NCH], m_ps[NCH], m_pend[NCH];
  int m_reload[NCH], m_count[NCH], m_div[NCH], m_irq[NCH];
  int m_rdata;
  int t_eff, t_mask, t_tick, t_exp, t_base, t_wc, t_ws, t_wr;

  function automatic int model_read(input int a);
    int c, o;
    if (a < 128) return 0;
    c = (a - 128) / 128;
    o = (a - 128) % 128;
    if (c >= NCH) return 0;
    case (o)
      0:  return (m_ie[c] << 8) | (m_en[c] << 5) | (m_os[c] << 4) | m_ps[c];
      4:  return m_pend[c];
      8:  return m_reload[c];
      12: return m_count[c];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ie[c] = 0; m_en[c] = 0; m_os[c] = 0; m_ps[c] = 0; m_pend[c] = 0;
        m_reload[c] = 0; m_count[c] = 0; m_div[c] = 0; m_irq[c] = 0;
      end
      m_rdata = 0;
    end else begin
      if (rd_en) m_rdata = model_read(int'(addr));
      for (int c = 0; c < NCH; c++) begin
        t_base = 128 + c * 128;
        t_wc = (wr_en && int'(addr) == t_base)      ? 1 : 0;
        t_ws = (wr_en && int'(addr) == t_base + 4)  ? 1 : 0;
        t_wr = (wr_en && int'(addr) == t_base + 8)  ? 1 : 0;
        t_eff  = (m_ps[c] > 8) ? 8 : m_ps[c];
        t_mask = (1 << t_eff) - 1;
        t_tick = (m_en[c] != 0 && m_div[c] == t_mask) ? 1 : 0;
        t_exp  = 0;
        if (t_wc != 0) begin
          if (wdata[5] && m_en[c] == 0) m_count[c] = m_reload[c];
          m_ie[c] = wdata[8]; m_en[c] = wdata[5]; m_os[c] = wdata[4];
          m_ps[c] = int'(wdata[3:0]);
          m_div[c] = 0;
        end else if (t_tick != 0) begin
          m_div[c] = 0;
          if (m_count[c] <= 1) begin
            t_exp = 1;
            if (m_os[c] != 0) begin m_en[c] = 0; m_count[c] = 0; end
            else m_count[c] = m_reload[c];
          end else m_count[c] = m_count[c] - 1;
        end else if (m_en[c] != 0) m_div[c] = m_div[c] + 1;
        else m_div[c] = 0;
        if (t_exp != 0) m_pend[c] = 1;
        else if (t_ws != 0 && wdata[0]) m_pend[c] = 0;
        if (t_wr != 0) m_reload[c] = int'(wdata);
        if (m_en[c] == 0) m_div[c] = 0;
        m_irq[c] = m_pend[c] & m_ie[c];
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) chk("R10 irq vs model", int'(irq[c]), m_irq[c]);
      chk("R2 rdata vs model", int'(rdata), m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 10'(a); wdata = 16'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1'b1; addr = 10'(a);
    @(negedge clk); rd_en = 1'b0; v = int'(rdata);
  endtask

  task automatic wait_irq(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 2000) begin @(negedge clk); n++; end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 16; o += 4) begin
        rd(128 + c * 128 + o, v); chk("R1 reset register", v, 0);
      end
    chk("R1 reset irq", int'(irq), 0);

    // R2 / R3: map and field layout
    wr(128 + 8, 16'h1234); rd(128 + 8, v); chk("R2 reload ch0", v, 16'h1234);
    wr(256 + 0, 16'hFFDF); rd(256 + 0, v); chk("R3 ctrl fields ch1", v, 16'h011F);
    wr(256 + 0, 0);        rd(256 + 0, v); chk("R3 ctrl cleared", v, 0);
    rd(0, v);     chk("R2 below base", v, 0);
    rd(128 + 16, v); chk("R2 gap offset", v, 0);
    rd(384, v);   chk("R2 missing channel", v, 0);

    // R5: count offset is read-only
    wr(128 + 12, 16'h5555); rd(128 + 12, v); chk("R5 count write ignored", v, 0);

    // R6 / R8 / R9: one-shot, reload 5, code 0
    wr(128 + 8, 5); wr(128 + 0, 16'h0130);
    wait_irq(0, n); chk("R6 expiry after reload ticks", n, 5);
    rd(128 + 0, v);  chk("R8 enable cleared", v, 16'h0110);
    rd(128 + 12, v); chk("R8 count zero", v, 0);
    rd(128 + 4, v);  chk("R9 pending set", v, 1);
    repeat (20) @(negedge clk);
    rd(128 + 12, v); chk("R8 count holds zero", v, 0);
    wr(128 + 4, 0); rd(128 + 4, v); chk("R9 write 0 keeps flag", v, 1);
    wr(128 + 4, 1); rd(128 + 4, v); chk("R9 write 1 clears flag", v, 0);
    chk("R10 irq low after clear", int'(irq[0]), 0);

    // R4: prescaler periods
    wr(128 + 8, 3); wr(128 + 0, 16'h0132);
    wait_irq(0, n); chk("R4 code 2 period", n, 12);
    wr(128 + 4, 1);
    wr(128 + 8, 2); wr(128 + 0, 16'h0139);
    wait_irq(0, n); chk("R4 code 9 clamps to 8", n, 512);
    wr(128 + 4, 1);

    // R4: control writes restart the divider and block ticks
    wr(128 + 8, 10); wr(128 + 0, 16'h0033);
    for (int k = 0; k < 20; k++) begin wr(128 + 0, 16'h0033); @(negedge clk); end
    rd(128 + 12, v); chk("R4 divider restart holds count", v, 10);
    wr(128 + 0, 0);

    // R7 / R11: auto-reload on ch1 while ch0 idles
    wr(128 + 4, 1);
    wr(256 + 8, 4); wr(256 + 0, 16'h0120);
    wait_irq(1, n); chk("R7 first autoreload expiry", n, 4);
    repeat (30) @(negedge clk);
    rd(256 + 0, v);  chk("R7 stays enabled", v, 16'h0120);
    rd(256 + 4, v);  chk("R7 pending set", v, 1);
    rd(128 + 4, v);  chk("R11 ch0 status untouched", v, 0);
    rd(128 + 12, v); chk("R11 ch0 count untouched", v, 10);
    chk("R11 ch0 irq low", int'(irq[0]), 0);
    wr(256 + 0, 0); wr(256 + 4, 1);

    // random traffic, compared with the model every clock (R4 R6 R7 R9 R11)
    for (int k = 0; k < 1500; k++) begin
      int ch, sel, d;
      ch  = $urandom % 3;
      sel = $urandom % 5;
      case (sel)
        0: d = int'($urandom) & 16'h01F3;
        1: d = $urandom % 2;
        2: d = $urandom % 9;
        default: d = int'($urandom) & 16'hFFFF;
      endcase
      if (sel == 4) rd(128 + ch * 128 + 4 * ($urandom % 4), v);
      else wr(128 + ch * 128 + 4 * (sel % 4), d);
    end

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule